// File: doc/BRIEF.md
# ISA I/O Wait-State Generator

This block sits on an ISA (PC/104-class) I/O bus in front of a slow serial-link adapter peripheral. It compares the full 20-bit bus address against two fixed I/O ports, one for data and one for status/control. It produces an active-low select for whichever port is hit. While that access is in progress it holds the bus ready line low, so that the host inserts wait states.

The wait is timed by a small binary counter clocked by the ISA bus clock. The counter is held in asynchronous clear whenever no port is being accessed. Once an access is decoded, the counter runs up to its terminal value, releases ready, and then holds that value until the access ends. Each access therefore sees exactly one wait period. The block also enables the data transceiver during a decoded access and points it toward the host on reads. The ready line is presented as an output-enable/value pair, so the pad can be open-drain or tri-state. It is driven only while a port is being accessed.

Top module: `isa_wait_gen`

## Requirements
- R1: With `aen` low and `ior_n` or `iow_n` low, address 0x150 (all 20 bits compared) drives `data_sel_n` low and leaves `stat_sel_n` high.
- R2: With `aen` low and a strobe low, address 0x160 drives `stat_sel_n` low and leaves `data_sel_n` high.
- R3: Any other address, including 0x151, 0x161, 0x14F and 0x10150, drives neither select low.
- R4: While `aen` is high, no select is low and `chrdy_oe` stays low, whatever the address.
- R5: While `ior_n` and `iow_n` are both high, no select is low and `chrdy_oe` stays low.
- R6: `chrdy_oe` is high exactly while a port is selected (after reset has been released) and low at all other times.
- R7: After a decoded access starts, `chrdy_out` is low until 7 rising edges of `bus_clk` have occurred (the terminal count of the 3-bit counter, 2^CNT_W-1), and it is high from then on.
- R8: Once `chrdy_out` has gone high, it stays high for the rest of that access, so there is one wait period per access.
- R9: When an access ends, even one shorter than the wait period, the counter is cleared, and the next access again waits the full 7 edges.
- R10: `xcvr_en_n` is low exactly while a port is selected. `xcvr_dir` is 1 (toward the host) when `ior_n` is low and 0 when `ior_n` is high.
- R11: While `rst_n` is low, and for two `bus_clk` edges after it rises, `chrdy_oe` stays low even during a decoded access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | ISA bus clock that times the wait |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | ISA address bus |
| aen | input | 1 | Address enable, high during DMA cycles |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| data_sel_n | output | 1 | Data-port select, active low |
| stat_sel_n | output | 1 | Status/control-port select, active low |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward host |
| chrdy_oe | output | 1 | Ready line drive enable |
| chrdy_out | output | 1 | Ready line value while driven (0 = wait) |

## Verification
The hardest situation to reach from the ports is an access that ends before the counter has expired, followed at once by another decoded access. Only that sequence shows whether the asynchronous clear really resets a partial count. The random stimulus draws hold lengths from 3 to 14 clocks, so many accesses are cut short. Each access is preceded by a single idle clock, so back-to-back partial and full waits occur often. Near-miss addresses (0x151, 0x161, 0x14F, an upper-bit alias) and DMA or strobe-less cycles are mixed in, to show that nothing is selected and ready is never driven.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;
  typedef struct packed {
    logic data_hit;
    logic stat_hit;
  } port_hit_t;

  function automatic logic strobe_active(input logic rd_n, input logic wr_n);
    return (!rd_n) || (!wr_n);
  endfunction
endpackage

// File: rtl/isa_rst_sync.sv
module isa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/isa_io_decode.sv
module isa_io_decode
  import isa_wait_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] DATA_PORT = 20'h00150,
  parameter logic [ADDR_W-1:0] STAT_PORT = 20'h00160
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic              ior_n,
  input  logic              iow_n,
  output port_hit_t         hit
);
  localparam int NPORTS = 2;
  localparam logic [NPORTS-1:0][ADDR_W-1:0] PORTS = {DATA_PORT, STAT_PORT};

  logic              cycle_ok;
  logic [NPORTS-1:0] match;

  assign cycle_ok = !aen && strobe_active(ior_n, iow_n);

  for (genvar i = 0; i < NPORTS; i++) begin : g_cmp
    assign match[i] = cycle_ok && (addr == PORTS[i]);
  end

  assign hit.data_hit = match[1];
  assign hit.stat_hit = match[0];
endmodule

// File: rtl/isa_wait_counter.sv
module isa_wait_counter #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic clr_n,
  output logic done
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_q != TERM);
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == TERM);

  assert_hold_term_R8: assert property (@(posedge clk) disable iff (!clr_n)
    done |=> done);

  assert_step_R7: assert property (@(posedge clk) disable iff (!clr_n)
    !done |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/isa_wait_gen.sv
module isa_wait_gen
  import isa_wait_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] DATA_PORT = 20'h00150,
  parameter logic [ADDR_W-1:0] STAT_PORT = 20'h00160,
  parameter int                CNT_W     = 3,
  parameter int                SYNC_LEN  = 2
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic              ior_n,
  input  logic              iow_n,
  output logic              data_sel_n,
  output logic              stat_sel_n,
  output logic              xcvr_en_n,
  output logic              xcvr_dir,
  output logic              chrdy_oe,
  output logic              chrdy_out
);
  port_hit_t hit;
  logic      access;
  logic      rst_sync_n;
  logic      clr_n;
  logic      cnt_done;

  isa_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(bus_clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  isa_io_decode #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .STAT_PORT(STAT_PORT)) u_dec (
    .addr(addr), .aen(aen), .ior_n(ior_n), .iow_n(iow_n), .hit(hit)
  );

  assign access = hit.data_hit || hit.stat_hit;
  assign clr_n  = rst_sync_n && access;

  isa_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(bus_clk), .clr_n(clr_n), .done(cnt_done)
  );

  assign data_sel_n = !hit.data_hit;
  assign stat_sel_n = !hit.stat_hit;
  assign xcvr_en_n  = !access;
  assign xcvr_dir   = !ior_n;
  assign chrdy_oe   = access && rst_sync_n;
  assign chrdy_out  = cnt_done;

  assert_aen_blocks_R4: assert property (@(posedge bus_clk) disable iff (!rst_n)
    aen |-> (data_sel_n && stat_sel_n && !chrdy_oe));

  assert_idle_release_R6: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (data_sel_n && stat_sel_n) |-> !chrdy_oe);

  assert_dir_read_R10: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (!xcvr_en_n && !ior_n) |-> xcvr_dir);

  assert_wait_first_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(chrdy_oe) |-> !chrdy_out);
endmodule

// File: tb/tb_isa_wait_gen.sv
module tb_isa_wait_gen;
  localparam int TERM = 7;

  logic        bus_clk = 1'b0;
  logic        rst_n;
  logic [19:0] addr;
  logic        aen, ior_n, iow_n;
  logic        data_sel_n, stat_sel_n, xcvr_en_n, xcvr_dir, chrdy_oe, chrdy_out;

  int vectors = 0;
  int errors  = 0;

  always #2 bus_clk = ~bus_clk;

  isa_wait_gen dut (
    .bus_clk(bus_clk), .rst_n(rst_n), .addr(addr), .aen(aen), .ior_n(ior_n),
    .iow_n(iow_n), .data_sel_n(data_sel_n), .stat_sel_n(stat_sel_n),
    .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir), .chrdy_oe(chrdy_oe),
    .chrdy_out(chrdy_out)
  );

  function automatic logic exp_data(logic [19:0] a, logic e, logic r, logic w);
    return !e && (!r || !w) && (a == 20'h00150);
  endfunction

  function automatic logic exp_stat(logic [19:0] a, logic e, logic r, logic w);
    return !e && (!r || !w) && (a == 20'h00160);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // k = rising edges since access start; rdy_en = reset released
  task automatic check_outputs(input int k, input logic rdy_en);
    logic ed, es, acc;
    ed  = exp_data(addr, aen, ior_n, iow_n);
    es  = exp_stat(addr, aen, ior_n, iow_n);
    acc = ed || es;
    chk(data_sel_n == !ed, "R1/R3/R4/R5 data_sel_n", data_sel_n, !ed);
    chk(stat_sel_n == !es, "R2/R3/R4/R5 stat_sel_n", stat_sel_n, !es);
    chk(chrdy_oe == (acc && rdy_en), "R6/R11 chrdy_oe", chrdy_oe, acc && rdy_en);
    chk(xcvr_en_n == !acc, "R10 xcvr_en_n", xcvr_en_n, !acc);
    chk(xcvr_dir == !ior_n, "R10 xcvr_dir", xcvr_dir, !ior_n);
    if (acc && rdy_en)
      chk(chrdy_out == (k >= TERM), "R7/R8/R9 chrdy_out", chrdy_out, k >= TERM);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge bus_clk);
      ior_n = 1'b1; iow_n = 1'b1; aen = 1'b0; addr = 20'h00000;
      #1 check_outputs(0, 1'b1);
    end
  endtask

  task automatic access(input logic [19:0] a, input logic e, input logic rd,
                        input logic strobe, input int hold);
    @(negedge bus_clk);
    addr = a; aen = e;
    ior_n = !(strobe && rd);
    iow_n = !(strobe && !rd);
    #1 check_outputs(0, 1'b1);
    for (int k = 1; k <= hold; k++) begin
      @(negedge bus_clk);
      #1 check_outputs(k, 1'b1);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [19:0] a;
    logic        e, rd, st;
    int          sel, hold;
    void'($urandom(1190));
    rst_n = 1'b0; addr = 20'h00150; aen = 1'b0; ior_n = 1'b0; iow_n = 1'b1;
    // R11: reset held during a decoded access: selects decode, ready not driven
    repeat (3) @(negedge bus_clk);
    #1 check_outputs(0, 1'b0);
    chk(chrdy_oe == 1'b0, "R11 chrdy_oe in reset", chrdy_oe, 0);
    ior_n = 1'b1;
    @(negedge bus_clk) rst_n = 1'b1;
    #1 chk(chrdy_oe == 1'b0, "R11 reset state idle", chrdy_oe, 0);
    idle(3);

    // directed corners
    access(20'h00150, 1'b0, 1'b1, 1'b1, 10);  // R1 read, R7/R8
    idle(1);
    access(20'h00160, 1'b0, 1'b0, 1'b1, 10);  // R2 write
    idle(1);
    access(20'h00151, 1'b0, 1'b1, 1'b1, 4);   // R3
    access(20'h00161, 1'b0, 1'b0, 1'b1, 4);   // R3
    access(20'h10150, 1'b0, 1'b1, 1'b1, 4);   // R3 upper-bit alias
    access(20'h00150, 1'b1, 1'b1, 1'b1, 9);   // R4 DMA cycle
    access(20'h00160, 1'b0, 1'b1, 1'b0, 4);   // R5 no strobe
    idle(1);
    access(20'h00150, 1'b0, 1'b0, 1'b1, 3);   // R9 cut short
    idle(1);
    access(20'h00150, 1'b0, 1'b0, 1'b1, 9);   // R9 full wait again
    idle(1);

    for (int n = 0; n < 300; n++) begin
      sel = int'($urandom % 8);
      case (sel)
        0, 7:    a = 20'h00150;
        1:       a = 20'h00160;
        2:       a = 20'h00151;
        3:       a = 20'h00161;
        4:       a = 20'h10150;
        5:       a = 20'h0014F;
        default: a = 20'($urandom);
      endcase
      e    = ($urandom % 6) == 0;
      rd   = $urandom % 2;
      st   = ($urandom % 8) != 0;
      hold = 3 + int'($urandom % 12);
      access(a, e, rd, st, hold);
      idle(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule